// File: doc/BRIEF.md
# UART Channel Sleep/Wake Controller

This block decides when an idle UART channel can drop into a low-power sleep state and when it has to come back out. It watches the channel's idle indicators (receive FIFO empty, transmit FIFO empty, transmitter shift logic idle, no interrupt pending), a software sleep-enable bit, writes to the transmit holding register and the receive-data pin. Its outputs are a sleep flag, which the surrounding logic uses to gate the channel's clock, and a one-cycle wake event.

A mode input sets how the receive pin is handled. In level mode a low receive line counts as activity. It blocks sleep, and once the channel is asleep a low line wakes it. In edge mode the channel may sleep whatever level the line holds. The synchronized line level is stored at the moment of entry, and any later departure from that stored level wakes the channel, whether the line rises or falls. After a wake, the entry conditions must be seen again for a full qualification window before the channel sleeps again. This stops the channel from bouncing in and out of sleep.

The controller itself runs on a free-running clock. The reset input is asynchronous active-low and is released through a local synchronizer.

Top module: `uart_sleep_ctrl`

## Requirements
- R1: While reset is applied, and in the cycles after it until the first entry, sleep_o and wake_o are both 0.
- R2: sleep_o rises only after all entry conditions have held for ENTRY_HOLD consecutive cycles (default 2). The entry conditions are: sleep_en_i=1, rx_fifo_empty_i=1, tx_fifo_empty_i=1, tx_idle_i=1, irq_pending_i=0 and thr_write_i=0. sleep_o goes to 1 on the clock edge that ends the last cycle of that window.
- R3: Sleep is never entered while any single idle indicator is false: receive FIFO not empty, transmit FIFO not empty, transmitter busy, or interrupt pending.
- R4: With edge_mode_i=0 (level mode), a synchronized receive pin at 0 blocks sleep entry.
- R5: In level mode, a sleeping channel wakes when the receive pin goes to 0. The wake takes effect on the third clock edge after the pin change: two synchronizer stages, then the state register.
- R6: With edge_mode_i=1 (edge mode), the channel enters sleep even while the receive pin is 0.
- R7: In edge mode, the synchronized pin level is stored on sleep entry. A change of the pin in either direction away from that stored level wakes the channel on the third edge after the change. A pin that holds its level keeps the channel asleep.
- R8: A thr_write_i pulse while asleep wakes the channel on the next clock edge. While thr_write_i is 1, sleep entry is blocked.
- R9: Clearing sleep_en_i while asleep wakes the channel on the next clock edge.
- R10: wake_o is a single-cycle pulse. It is 1 in exactly the first cycle in which sleep_o is back at 0 after sleeping.
- R11: The wake cycle does not count toward qualification. The earliest re-entry sets sleep_o in the cycle ENTRY_HOLD+1 cycles after the wake_o cycle, and sleep_o is never 1 in the cycle right after it falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_en_i | input | 1 | Software sleep enable |
| edge_mode_i | input | 1 | Receive pin handling: 0 level, 1 edge |
| rx_fifo_empty_i | input | 1 | Receive FIFO holds no data |
| tx_fifo_empty_i | input | 1 | Transmit FIFO holds no data |
| tx_idle_i | input | 1 | Transmit shifter has finished the last stop bit |
| irq_pending_i | input | 1 | Channel has an interrupt outstanding |
| thr_write_i | input | 1 | Host write to the transmit holding register, one cycle |
| rx_pin_i | input | 1 | Asynchronous receive-data pin |
| sleep_o | output | 1 | Channel is asleep; used to gate the channel clock |
| wake_o | output | 1 | One-cycle pulse when the channel leaves sleep |

## Verification
The hardest case to reach is an edge-mode wake from a channel that went to sleep with the receive line already low. A rising pin must wake it, and a line that simply stays low must not. To get there, the bench first moves the pin low and waits until the low level has passed through both synchronizer stages. Only then does it raise the idle conditions, so that the stored reference is 0. It then either holds the pin steady for many cycles or raises it, and checks the wake on the exact third edge. The re-entry guard is reached by leaving every idle condition true across a one-cycle transmit write, so that the only thing that delays the return to sleep is the qualification window.

// File: rtl/uart_sleep_pkg.sv
package uart_sleep_pkg;

  typedef enum logic {
    SLP_AWAKE  = 1'b0,
    SLP_ASLEEP = 1'b1
  } slp_state_e;

  typedef struct packed {
    logic sleep_en;
    logic rx_fifo_empty;
    logic tx_fifo_empty;
    logic tx_idle;
    logic irq_pending;
    logic thr_write;
  } slp_cond_t;

endpackage

// File: rtl/slp_reset_sync.sv
module slp_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/slp_pin_sync.sv
module slp_pin_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic pin_s_o
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  // The pin enters at stage 0; each later stage copies the stage before it.
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign stage_d[i] = pin_i;
      end else begin : g_next
        assign stage_d[i] = stage_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= {STAGES{RESET_VAL}};
    end else begin
      stage_q <= stage_d;
    end
  end

  assign pin_s_o = stage_q[STAGES-1];

endmodule

// File: rtl/slp_entry_qual.sv
module slp_entry_qual
  import uart_sleep_pkg::*;
#(
  parameter int unsigned ENTRY_HOLD = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  slp_cond_t cond_i,
  input  logic      edge_mode_i,
  input  logic      rx_s_i,
  input  logic      asleep_i,
  input  logic      wake_cycle_i,
  output logic      enter_o
);

  localparam int unsigned CNT_W = (ENTRY_HOLD > 1) ? $clog2(ENTRY_HOLD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ENTRY_HOLD - 1);

  logic             idle_ok;
  logic             pin_ok;
  logic             cond_ok;
  logic             count_en;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign idle_ok = cond_i.sleep_en & cond_i.rx_fifo_empty & cond_i.tx_fifo_empty
                 & cond_i.tx_idle & ~cond_i.irq_pending & ~cond_i.thr_write;
  // In level mode a low line is activity; in edge mode the line level is ignored.
  assign pin_ok  = edge_mode_i | rx_s_i;
  assign cond_ok = idle_ok & pin_ok;

  // The cycle that carries the wake pulse never counts toward qualification.
  assign count_en = ~asleep_i & ~wake_cycle_i;

  assign enter_o = count_en & cond_ok & (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (asleep_i || !cond_ok) begin
      cnt_d = '0;
    end else if (count_en && (cnt_q != CNT_LAST)) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/slp_wake_detect.sv
module slp_wake_detect
  import uart_sleep_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  slp_cond_t cond_i,
  input  logic      edge_mode_i,
  input  logic      rx_s_i,
  input  logic      asleep_i,
  input  logic      enter_i,
  output logic      wake_o
);

  logic ref_q;
  logic ref_d;
  logic ref_en;
  logic pin_wake;

  // The line level at the entry edge is kept as the reference for edge mode.
  assign ref_en = enter_i;

  always_comb begin
    ref_d = ref_q;
    if (ref_en) begin
      ref_d = rx_s_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b1;
    end else begin
      ref_q <= ref_d;
    end
  end

  assign pin_wake = edge_mode_i ? (rx_s_i ^ ref_q) : ~rx_s_i;

  assign wake_o = asleep_i & (pin_wake | cond_i.thr_write | ~cond_i.sleep_en);

endmodule

// File: rtl/uart_sleep_ctrl.sv
module uart_sleep_ctrl
  import uart_sleep_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2,
  parameter int unsigned ENTRY_HOLD  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_en_i,
  input  logic edge_mode_i,
  input  logic rx_fifo_empty_i,
  input  logic tx_fifo_empty_i,
  input  logic tx_idle_i,
  input  logic irq_pending_i,
  input  logic thr_write_i,
  input  logic rx_pin_i,
  output logic sleep_o,
  output logic wake_o
);

  slp_state_e state_q;
  slp_state_e state_d;
  logic       wake_q;
  logic       wake_d;
  logic       rst_sync_n;
  logic       rx_s;
  logic       asleep;
  logic       enter_req;
  logic       wake_req;
  slp_cond_t  cond;

  assign cond = '{
    sleep_en:      sleep_en_i,
    rx_fifo_empty: rx_fifo_empty_i,
    tx_fifo_empty: tx_fifo_empty_i,
    tx_idle:       tx_idle_i,
    irq_pending:   irq_pending_i,
    thr_write:     thr_write_i
  };

  slp_reset_sync #(
    .STAGES (RST_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  slp_pin_sync #(
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b1)
  ) u_rx_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .pin_i   (rx_pin_i),
    .pin_s_o (rx_s)
  );

  assign asleep = (state_q == SLP_ASLEEP);

  slp_entry_qual #(
    .ENTRY_HOLD (ENTRY_HOLD)
  ) u_entry (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .cond_i       (cond),
    .edge_mode_i  (edge_mode_i),
    .rx_s_i       (rx_s),
    .asleep_i     (asleep),
    .wake_cycle_i (wake_q),
    .enter_o      (enter_req)
  );

  slp_wake_detect u_wake (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cond_i      (cond),
    .edge_mode_i (edge_mode_i),
    .rx_s_i      (rx_s),
    .asleep_i    (asleep),
    .enter_i     (enter_req),
    .wake_o      (wake_req)
  );

  always_comb begin
    state_d = state_q;
    wake_d  = 1'b0;
    unique case (state_q)
      SLP_AWAKE: begin
        if (enter_req) begin
          state_d = SLP_ASLEEP;
        end
      end
      SLP_ASLEEP: begin
        if (wake_req) begin
          state_d = SLP_AWAKE;
          wake_d  = 1'b1;
        end
      end
      default: begin
        state_d = SLP_AWAKE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= SLP_AWAKE;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= wake_d;
    end
  end

  assign sleep_o = asleep;
  assign wake_o  = wake_q;

  AST_ENTRY_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(sleep_o) |-> $past(sleep_en_i && rx_fifo_empty_i && tx_fifo_empty_i
                             && tx_idle_i && !irq_pending_i && !thr_write_i)); // R2

  AST_LEVEL_PIN_HIGH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(sleep_o) && !$past(edge_mode_i)) |-> $past(rx_s)); // R4

  AST_THR_WAKES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sleep_o && thr_write_i) |=> (!sleep_o && wake_o)); // R8

  AST_EN_CLEAR_WAKES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sleep_o && !sleep_en_i) |=> (!sleep_o && wake_o)); // R9

  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wake_o |-> (!sleep_o && $past(sleep_o))); // R10

  AST_NO_QUICK_REENTRY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(sleep_o) |=> !sleep_o); // R11

endmodule

// File: tb/uart_sleep_ctrl_tb.sv
module uart_sleep_ctrl_tb;

  logic clk;
  logic rst_n;
  logic sleep_en_i;
  logic edge_mode_i;
  logic rx_fifo_empty_i;
  logic tx_fifo_empty_i;
  logic tx_idle_i;
  logic irq_pending_i;
  logic thr_write_i;
  logic rx_pin_i;
  logic sleep_o;
  logic wake_o;

  int checks;
  int failures;
  bit done;

  uart_sleep_ctrl u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .sleep_en_i      (sleep_en_i),
    .edge_mode_i     (edge_mode_i),
    .rx_fifo_empty_i (rx_fifo_empty_i),
    .tx_fifo_empty_i (tx_fifo_empty_i),
    .tx_idle_i       (tx_idle_i),
    .irq_pending_i   (irq_pending_i),
    .thr_write_i     (thr_write_i),
    .rx_pin_i        (rx_pin_i),
    .sleep_o         (sleep_o),
    .wake_o          (wake_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Return to a known awake state with every condition idle, level mode, line high.
  task automatic park();
    sleep_en_i      = 1'b0;
    edge_mode_i     = 1'b0;
    rx_fifo_empty_i = 1'b1;
    tx_fifo_empty_i = 1'b1;
    tx_idle_i       = 1'b1;
    irq_pending_i   = 1'b0;
    thr_write_i     = 1'b0;
    rx_pin_i        = 1'b1;
    cyc(6);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    park();
    chk("R1", "sleep_o in reset", sleep_o, 1'b0);
    chk("R1", "wake_o in reset", wake_o, 1'b0);
    rst_n = 1'b1;
    cyc(5);
    chk("R1", "sleep_o after reset", sleep_o, 1'b0);
    chk("R1", "wake_o after reset", wake_o, 1'b0);
  endtask

  task automatic t_enter_basic();
    park();
    sleep_en_i = 1'b1;
    cyc(1);
    chk("R2", "sleep_o after one qualifying cycle", sleep_o, 1'b0);
    cyc(1);
    chk("R2", "sleep_o after two qualifying cycles", sleep_o, 1'b1);
    chk("R2", "wake_o on entry", wake_o, 1'b0);
  endtask

  task automatic t_idle_blocks();
    for (int k = 0; k < 4; k++) begin
      park();
      case (k)
        0: rx_fifo_empty_i = 1'b0;
        1: tx_fifo_empty_i = 1'b0;
        2: tx_idle_i       = 1'b0;
        default: irq_pending_i = 1'b1;
      endcase
      sleep_en_i = 1'b1;
      cyc(8);
      chk("R3", $sformatf("blocked by indicator %0d", k), sleep_o, 1'b0);
    end
  endtask

  task automatic t_level_block();
    park();
    rx_pin_i = 1'b0;
    cyc(4);
    sleep_en_i = 1'b1;
    cyc(8);
    chk("R4", "low line blocks entry in level mode", sleep_o, 1'b0);
  endtask

  task automatic t_level_wake();
    park();
    sleep_en_i = 1'b1;
    cyc(3);
    chk("R5", "asleep before line drop", sleep_o, 1'b1);
    rx_pin_i = 1'b0;
    cyc(2);
    chk("R5", "still asleep after two edges", sleep_o, 1'b1);
    cyc(1);
    chk("R5", "awake on third edge", sleep_o, 1'b0);
    chk("R10", "wake pulse with level wake", wake_o, 1'b1);
    cyc(1);
    chk("R10", "wake pulse lasts one cycle", wake_o, 1'b0);
    cyc(8);
    chk("R4", "no re-entry while line low", sleep_o, 1'b0);
  endtask

  task automatic t_edge_low_entry();
    park();
    edge_mode_i = 1'b1;
    rx_pin_i    = 1'b0;
    cyc(4);
    sleep_en_i = 1'b1;
    cyc(2);
    chk("R6", "edge mode enters with line low", sleep_o, 1'b1);
    cyc(20);
    chk("R7", "steady low line keeps sleep", sleep_o, 1'b1);
    chk("R7", "no wake on steady line", wake_o, 1'b0);
    rx_pin_i = 1'b1;
    cyc(2);
    chk("R7", "still asleep two edges after rise", sleep_o, 1'b1);
    cyc(1);
    chk("R7", "rise wakes on third edge", sleep_o, 1'b0);
    chk("R10", "wake pulse on rise", wake_o, 1'b1);
  endtask

  task automatic t_edge_fall_wake();
    park();
    edge_mode_i = 1'b1;
    sleep_en_i  = 1'b1;
    cyc(2);
    chk("R6", "edge mode enters with line high", sleep_o, 1'b1);
    cyc(15);
    chk("R7", "steady high line keeps sleep", sleep_o, 1'b1);
    rx_pin_i = 1'b0;
    cyc(3);
    chk("R7", "fall wakes on third edge", wake_o, 1'b1);
    chk("R7", "sleep_o cleared on fall wake", sleep_o, 1'b0);
  endtask

  task automatic t_thr_wake_reentry();
    park();
    sleep_en_i = 1'b1;
    cyc(3);
    chk("R8", "asleep before write", sleep_o, 1'b1);
    thr_write_i = 1'b1;
    cyc(1);
    thr_write_i = 1'b0;
    chk("R8", "write wakes on next edge", sleep_o, 1'b0);
    chk("R10", "wake pulse on write", wake_o, 1'b1);
    cyc(1);
    chk("R10", "wake pulse ends", wake_o, 1'b0);
    chk("R11", "no sleep one cycle after wake", sleep_o, 1'b0);
    cyc(1);
    chk("R11", "no sleep two cycles after wake", sleep_o, 1'b0);
    cyc(1);
    chk("R11", "re-entry three cycles after wake", sleep_o, 1'b1);
  endtask

  task automatic t_thr_blocks();
    park();
    sleep_en_i  = 1'b1;
    thr_write_i = 1'b1;
    cyc(6);
    chk("R8", "held write blocks entry", sleep_o, 1'b0);
    thr_write_i = 1'b0;
    cyc(2);
    chk("R2", "entry once write released", sleep_o, 1'b1);
  endtask

  task automatic t_en_clear();
    park();
    sleep_en_i = 1'b1;
    cyc(3);
    chk("R9", "asleep before enable clear", sleep_o, 1'b1);
    sleep_en_i = 1'b0;
    cyc(1);
    chk("R9", "enable clear wakes on next edge", sleep_o, 1'b0);
    chk("R9", "wake pulse on enable clear", wake_o, 1'b1);
    cyc(6);
    chk("R9", "stays awake with enable clear", sleep_o, 1'b0);
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    done     = 1'b0;
    t_reset();
    t_enter_basic();
    t_idle_blocks();
    t_level_block();
    t_level_wake();
    t_edge_low_entry();
    t_edge_fall_wake();
    t_thr_wake_reentry();
    t_thr_blocks();
    t_en_clear();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule